// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It holds 2,048 bytes as plain registers and needs no internal write cycle. Both bus lines are resampled in the system clock domain. The block detects start and stop conditions, shifts bytes in and out, and drives acknowledge bits by pulling the data line low. It never drives the clock line and never begins a transfer on its own.

Each transaction opens with a select byte. This byte carries a fixed 4-bit device code, the top three bits of the byte address (the segment) and a direction flag. On a write, the next byte is the row, and each byte after it is stored and acknowledged. On a read, bytes come out of the current address pointer. A random read is a write select plus a row byte, followed by a repeated start and a read select. A write is complete by the end of its own acknowledge clock, so the next select byte is acknowledged at once and no busy polling is needed.

Top module: `twi_byte_mem`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe_o` = 0) and waits for a start condition.
- R2: A select byte whose upper four bits are 1010 is acknowledged by holding the data line low for the whole of the ninth clock. Bit 0 of that byte is the direction flag: 0 means write and 1 means read.
- R3: A select byte with any other upper four bits gets no acknowledge. The slave then keeps the data line released and stores nothing until the next start condition.
- R4: In a write, select bits [3:1] form address bits [10:8] and the following row byte forms address bits [7:0]. The row byte and every data byte are acknowledged. Each data byte is stored at the current address.
- R5: After each stored or transmitted byte, the address advances by one. It wraps from 2047 to 0 and carries across segment boundaries.
- R6: A read sends the byte at the current address, most significant bit first, and continues from wherever the last access left the pointer. Select bits [3:1] of a read select are ignored.
- R7: A master acknowledge during a read makes the slave send the next byte. A master not-acknowledge ends the read, and the slave keeps the data line released until the next start condition.
- R8: A write select, a row byte, a repeated start and a read select together return the data at the addressed location.
- R9: Written data can be read back in the very next transaction, and that transaction's select byte is acknowledged with no busy period.
- R10: A falling data line while the clock is high is a start condition, and it restarts framing from any state. A rising data line while the clock is high is a stop condition, which returns the slave to idle. Data-line changes while the clock is low count as data.
- R11: Reset in the middle of a transaction, even during an acknowledge, releases the data line at once. The next transaction then works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Two situations are hard to reach from the bus. The first is the pointer wrapping from location 2047 to 0. The stimulus selects segment 7 and row 0xFF, writes two bytes, and then reads both the top location and location 0 back through random reads. The second is a reset landing while the slave pulls the data line low with the clock high. The bench hand-clocks a row byte bit by bit, stops in the high phase of the ninth clock, confirms the acknowledge is present, and asserts reset there. A restart in the middle of a byte is covered by issuing a start after four bits of a row byte.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ROW,
    ST_WR,
    ST_RD
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[1:0], line_i};
  end

  assign lvl_o  = pipe_q[1];
  assign rise_o = pipe_q[1] & ~pipe_q[2];
  assign fall_o = ~pipe_q[1] & pipe_q[2];
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
  import twi_mem_pkg::*;
#(
  parameter int         ADDR_W   = 11,
  parameter int         ROW_W    = 8,
  parameter int         DATA_W   = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              sda_oe_o
);
  localparam int SEG_W = ADDR_W - ROW_W;
  localparam int DEV_W = DATA_W - 1 - SEG_W;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

  twi_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEG_W-1:0]  seg_q;
  logic              oe_q;

  logic start_det, stop_det, byte_done, dev_match;

  assign start_det = scl_lvl_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & sda_rise_i;
  assign byte_done = scl_fall_i && (bit_cnt_q == ACK_SLOT);
  assign dev_match = shreg_q[DATA_W-1 -: DEV_W] == DEV_CODE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      seg_q     <= '0;
      oe_q      <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise_i) begin
        if (bit_cnt_q != ACK_SLOT) begin
          shreg_q   <= {shreg_q[DATA_W-2:0], sda_lvl_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else begin
          bit_cnt_q <= '0;
          // master NACK ends a read
          if (state_q == ST_RD && sda_lvl_i) state_q <= ST_IDLE;
        end
      end else if (scl_fall_i) begin
        if (bit_cnt_q == ACK_SLOT) begin
          unique case (state_q)
            ST_DEV: begin
              if (dev_match) begin
                oe_q    <= 1'b1;
                seg_q   <= shreg_q[SEG_W:1];
                state_q <= shreg_q[0] ? ST_RD : ST_ROW;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_ROW: begin
              addr_q  <= {seg_q, shreg_q[ROW_W-1:0]};
              oe_q    <= 1'b1;
              state_q <= ST_WR;
            end
            ST_WR: begin
              addr_q <= addr_q + 1'b1;
              oe_q   <= 1'b1;
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (bit_cnt_q == '0) begin
          if (state_q == ST_RD) begin
            oe_q   <= ~mem_rdata_i[DATA_W-1];
            tx_q   <= {mem_rdata_i[DATA_W-2:0], 1'b0};
            addr_q <= addr_q + 1'b1;
          end else begin
            oe_q <= 1'b0;
          end
        end else if (state_q == ST_RD) begin
          oe_q <= ~tx_q[DATA_W-1];
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign mem_we_o    = byte_done && (state_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = shreg_q;
  assign sda_oe_o    = oe_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_lvl_i); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q); // R3
  AST_BIT_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= ACK_SLOT); // R4
  AST_WR_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R5
  AST_START_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_DEV && bit_cnt_q == '0 && !oe_q)); // R10
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !oe_q)); // R10
endmodule

// File: rtl/twi_byte_mem.sv
module twi_byte_mem #(
  parameter int         ADDR_W   = 11,
  parameter int         ROW_W    = 8,
  parameter int         DATA_W   = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int N_LINES = 2;
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic [N_LINES-1:0] line_in, line_lvl, line_rise, line_fall;
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_addr;
  logic [DATA_W-1:0]  mem_wdata, mem_rdata;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    twi_line_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_in[g]),
      .lvl_o  (line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  twi_slave_ctrl #(
    .ADDR_W   (ADDR_W),
    .ROW_W    (ROW_W),
    .DATA_W   (DATA_W),
    .DEV_CODE (DEV_CODE)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_lvl_i   (line_lvl[SCL_IDX]),
    .scl_rise_i  (line_rise[SCL_IDX]),
    .scl_fall_i  (line_fall[SCL_IDX]),
    .sda_lvl_i   (line_lvl[SDA_IDX]),
    .sda_rise_i  (line_rise[SDA_IDX]),
    .sda_fall_i  (line_fall[SDA_IDX]),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .sda_oe_o    (sda_oe_o)
  );

  twi_mem_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/twi_byte_mem_tb_top.sv
module twi_byte_mem_tb_top;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   checks = 0;
  int   errors = 0;
  logic [7:0] wdat [9];

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  twi_byte_mem dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wait_clk(HALF / 2);
    sda_m = 1'b1; wait_clk(HALF / 2);
    scl_m = 1'b1; wait_clk(HALF / 2);
    sda_m = 1'b0; wait_clk(HALF / 2);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wait_clk(HALF / 2);
    sda_m = 1'b0; wait_clk(HALF / 2);
    scl_m = 1'b1; wait_clk(HALF / 2);
    sda_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    scl_m = 1'b0; wait_clk(HALF / 2);
    sda_m = b;    wait_clk(HALF / 2);
    scl_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic recv_bit(output logic b);
    scl_m = 1'b0; wait_clk(HALF / 2);
    sda_m = 1'b1; wait_clk(HALF / 2);
    scl_m = 1'b1; wait_clk(HALF / 2);
    b = sda_bus;  wait_clk(HALF / 2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~more);
  endtask

  // write select + row, repeated start, read select
  task automatic point_read(input logic [2:0] seg, input logic [7:0] row, input string req);
    logic a;
    bus_start();
    send_byte({4'b1010, seg, 1'b0}, a); check(req, a, 1'b1);
    send_byte(row, a);                  check(req, a, 1'b1);
    bus_start();
    send_byte(8'b1010_0001, a);         check(req, a, 1'b1);
  endtask

  task automatic t_reset();
    wait_clk(5);
    check("R1", sda_oe, 1'b0);
    rst_ni = 1'b1;
    wait_clk(10);
    check("R1", sda_oe, 1'b0);
    check("R1", sda_bus, 1'b1);
  endtask

  task automatic t_seq_write();
    logic a;
    bus_start();
    send_byte(8'b1010_0100, a); check("R2", a, 1'b1);
    send_byte(8'hFC, a);        check("R4", a, 1'b1);
    for (int i = 0; i < 9; i++) begin
      wdat[i] = 8'($urandom);
      send_byte(wdat[i], a);
      check("R4", a, 1'b1);
    end
    bus_stop();
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'b1010_0100, a); check("R9", a, 1'b1);
    send_byte(8'hFC, a);        check("R8", a, 1'b1);
    bus_start();
    send_byte(8'b1010_1111, a); check("R6", a, 1'b1);  // segment bits ignored
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i != 7);
      check("R8", d, wdat[i]);  // crosses 0x2FF -> 0x300
    end
    recv_byte(d, 1'b0);
    check("R7", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'b1010_0011, a); check("R6", a, 1'b1);
    recv_byte(d, 1'b0);
    check("R6", d, wdat[8]);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'b1010_1110, a); check("R5", a, 1'b1);
    send_byte(8'hFF, a);        check("R5", a, 1'b1);
    send_byte(8'h3C, a);        check("R5", a, 1'b1);
    send_byte(8'hC3, a);        check("R5", a, 1'b1);
    bus_stop();
    point_read(3'd7, 8'hFF, "R5");
    recv_byte(d, 1'b1); check("R5", d, 8'h3C);
    recv_byte(d, 1'b0); check("R5", d, 8'hC3);
    bus_stop();
    point_read(3'd0, 8'h00, "R5");
    recv_byte(d, 1'b0); check("R5", d, 8'hC3);
    bus_stop();
  endtask

  task automatic t_foreign();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'b1011_0000, a); check("R3", a, 1'b0);
    send_byte(8'h00, a);        check("R3", a, 1'b0);
    send_byte(8'h5A, a);        check("R3", a, 1'b0);
    bus_stop();
    point_read(3'd0, 8'h00, "R3");
    recv_byte(d, 1'b0); check("R3", d, 8'hC3);
    bus_stop();
  endtask

  task automatic t_conditions();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'b1010_0000, a); check("R10", a, 1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'b1010_0000, a); check("R10", a, 1'b1);
    send_byte(8'h10, a);        check("R10", a, 1'b1);
    send_byte(8'h77, a);        check("R10", a, 1'b1);
    bus_stop();
    point_read(3'd0, 8'h10, "R10");
    recv_byte(d, 1'b0); check("R10", d, 8'h77);
    bus_stop();
    // bytes clocked after a stop with no start are ignored
    send_byte(8'b1010_0000, a); check("R10", a, 1'b0);
    send_byte(8'h10, a);        check("R10", a, 1'b0);
    bus_stop();
  endtask

  task automatic t_reset_mid();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'b1010_0000, a); check("R11", a, 1'b1);
    for (int i = 7; i >= 0; i--) send_bit(1'(8'h20 >> i));
    scl_m = 1'b0; wait_clk(HALF / 2);
    sda_m = 1'b1; wait_clk(HALF / 2);
    scl_m = 1'b1; wait_clk(HALF / 2);
    check("R4", sda_oe, 1'b1);
    rst_ni = 1'b0;
    wait_clk(2);
    check("R11", sda_oe, 1'b0);
    rst_ni = 1'b1;
    wait_clk(HALF);
    check("R11", sda_bus, 1'b1);
    bus_stop();
    bus_start();
    send_byte(8'b1010_0000, a); check("R11", a, 1'b1);
    send_byte(8'h20, a);        check("R11", a, 1'b1);
    send_byte(8'h42, a);        check("R11", a, 1'b1);
    bus_stop();
    point_read(3'd0, 8'h20, "R11");
    recv_byte(d, 1'b0); check("R11", d, 8'h42);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_seq_write();
    t_random_read();
    t_current_read();
    t_wrap();
    t_foreign();
    t_conditions();
    t_reset_mid();
    wait_clk(10);
    finish_run();
  end
endmodule